// File: doc/BRIEF.md
# Serial-Clocked Successive-Approximation Conversion Controller

This block is the digital half of a 12-bit successive-approximation converter. It is paced only by a serial clock and an active-low chip select. A falling chip select starts a frame. Then, one serial clock at a time, the block places a trial bit on a parallel DAC code and reads a single comparator bit. It keeps or clears the trial bit and moves the next trial to the next lower weight. Every decided bit is streamed out on a serial data line at once, so a host reading the line receives the result most significant bit first while the conversion is still running.

A frame lasts sixteen serial clocks. The first four carry zeros, and the next twelve carry the result in straight binary. If the host raises chip select early, the conversion stops at once. The bits already shifted form a lower-resolution reading. The parallel result register and the completion strobe change only for a full conversion.

Whenever chip select is high, or the frame is finished, the block reports that the analog side may power down. This takes no particular number of clocks.

Top module: `sar_serial_ctrl`

## Requirements
- R1: A rising serial clock edge that samples chip select low, after the previous edge sampled it high, starts a frame. This edge is frame edge 0. The data line is driven from this edge until edge 16 or until chip select rises.
- R2: After frame edge k (k = 0..15), the data line carries frame bit k. Bits 0 to 3 are 0. Bit 4+i is result bit 11-i, so the most significant bit comes first.
- R3: At frame edge 3 the DAC code becomes 0x800. At frame edge 4+i the comparator is sampled. A 1 keeps code bit 11-i and a 0 clears it, and code bit 10-i is set as the next trial (for i < 11).
- R4: With an ideal comparator (1 when the input code is at least the DAC code), a full frame returns the input code exactly, for codes from 0x000 to 0xFFF.
- R5: While chip select is high, the data-enable output is low and the data line is released. A conversion in progress stops.
- R6: When chip select rises before frame edge 16, the bits already shifted match the leading bits of a full frame. The parallel result and the done strobe stay unchanged.
- R7: The power-down output is high whenever chip select is high or no frame is running. It is low from frame edge 0 until the frame ends.
- R8: From frame edge 16 the data line is released. Further clocks with chip select still low have no effect until chip select goes high and then low again.
- R9: The done output is high for exactly one clock after frame edge 15. At that same edge the parallel result takes the 12-bit code, and it changes at no other time except reset.
- R10: An asynchronous active-low reset clears the DAC code, the result, done and the data enable, and forces the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | serial clock; all state changes on its rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| cs_n | input | 1 | chip select, active low |
| comp_in | input | 1 | comparator decision, 1 = held input at or above DAC code |
| dac_code | output | 12 | trial code for the capacitor DAC |
| sdo | output | 1 | serial data, high impedance when not enabled |
| sdo_oe | output | 1 | data line enable |
| pwr_dn | output | 1 | idle indication for the analog side |
| result | output | 12 | last full conversion result |
| done | output | 1 | one-clock strobe after a full conversion |

## Verification
The assertions assume that chip select and the comparator change only between rising serial clock edges. They also assume the comparator settles within half a clock after the DAC code moves. The bench drives every input half a period away from the rising edge, and it computes the comparator from the DAC code combinationally, so both assumptions hold. The properties also take for granted that a frame is never shorter than two clocks between done strobes, which follows from the sixteen-clock frame.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } frame_st_t;

  // frame length in serial clocks
  function automatic int frame_len(input int lead, input int res);
    return lead + res;
  endfunction

  // width needed to count up to and including n
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
  import sar_ctrl_pkg::*;
#(
  parameter int LEAD = 4,
  parameter int RES  = 12,
  parameter int PW   = $clog2(RES)
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          cs_n,
  output logic          running,
  output logic          ev_start,
  output logic          ev_step,
  output logic          ev_trial,
  output logic          ev_decide,
  output logic          ev_last,
  output logic          ev_end,
  output logic [PW-1:0] bit_pos
);
  localparam int FRAME = frame_len(LEAD, RES);
  localparam int CW    = cnt_width(FRAME);

  frame_st_t      st_q;
  logic           cs_prev_q;
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  e_idx;

  assign running  = (st_q == ST_RUN);
  assign ev_start = cs_prev_q & ~cs_n;
  assign ev_step  = ev_start | (running & ~cs_n);
  assign e_idx    = ev_start ? '0 : CW'(cnt_q + 1'b1);

  assign ev_trial  = ev_step & (e_idx == CW'(LEAD - 1));
  assign ev_decide = ev_step & (e_idx >= CW'(LEAD)) & (e_idx < CW'(FRAME));
  assign ev_last   = ev_step & (e_idx == CW'(FRAME - 1));
  assign ev_end    = ev_step & (e_idx == CW'(FRAME));
  assign bit_pos   = PW'(CW'(FRAME - 1) - e_idx);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q <= 1'b1;
      cnt_q     <= '0;
      st_q      <= ST_IDLE;
    end else begin
      cs_prev_q <= cs_n;
      if (cs_n) begin
        st_q <= ST_IDLE;
      end else if (ev_end) begin
        st_q <= ST_HOLD;
      end else if (ev_start) begin
        st_q <= ST_RUN;
      end
      if (ev_step) cnt_q <= e_idx;
    end
  end

endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg #(
  parameter int RES = 12,
  parameter int PW  = $clog2(RES)
) (
  input  logic           sclk,
  input  logic           rst_n,
  input  logic           ev_start,
  input  logic           ev_trial,
  input  logic           ev_decide,
  input  logic           ev_last,
  input  logic [PW-1:0]  bit_pos,
  input  logic           comp_in,
  output logic [RES-1:0] dac_code,
  output logic [RES-1:0] result,
  output logic           done
);
  // keep or drop the bit under trial, then arm the next lower weight
  function automatic logic [RES-1:0] settle_bit(input logic [RES-1:0] code,
                                                input logic [PW-1:0]  pos,
                                                input logic           keep);
    logic [RES-1:0] r;
    r = code;
    for (int b = 0; b < RES; b++) begin
      if (b == int'(pos))          r[b] = keep;
      else if (b + 1 == int'(pos)) r[b] = 1'b1;
    end
    return r;
  endfunction

  logic [RES-1:0] code_q;
  logic [RES-1:0] res_q;
  logic           done_q;
  logic [RES-1:0] next_code;

  assign next_code = settle_bit(code_q, bit_pos, comp_in);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ev_start) begin
        code_q <= '0;
      end
      if (ev_trial) begin
        code_q <= {1'b1, {(RES-1){1'b0}}};
      end else if (ev_decide) begin
        code_q <= next_code;
      end
      if (ev_last) begin
        res_q  <= next_code;
        done_q <= 1'b1;
      end
    end
  end

  assign dac_code = code_q;
  assign result   = res_q;
  assign done     = done_q;

endmodule

// File: rtl/sar_out_shift.sv
module sar_out_shift (
  input  logic sclk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic ev_start,
  input  logic ev_step,
  input  logic ev_decide,
  input  logic ev_end,
  input  logic comp_in,
  output logic sdo_bit,
  output logic sdo_oe
);
  logic bit_q;
  logic oe_q;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      if (ev_step) bit_q <= ev_decide & comp_in;
      if (cs_n)          oe_q <= 1'b0;
      else if (ev_end)   oe_q <= 1'b0;
      else if (ev_start) oe_q <= 1'b1;
    end
  end

  assign sdo_bit = bit_q;
  assign sdo_oe  = oe_q & ~cs_n;

endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl #(
  parameter int LEAD = 4,
  parameter int RES  = 12
) (
  input  logic           sclk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           comp_in,
  output logic [RES-1:0] dac_code,
  output logic           sdo,
  output logic           sdo_oe,
  output logic           pwr_dn,
  output logic [RES-1:0] result,
  output logic           done
);
  localparam int PW = $clog2(RES);

  // internal events, named for the checker
  logic          running;
  logic          ev_start;
  logic          ev_step;
  logic          ev_trial;
  logic          ev_decide;
  logic          ev_last;
  logic          ev_end;
  logic [PW-1:0] bit_pos;
  logic          sdo_bit;

  sar_frame_seq #(.LEAD(LEAD), .RES(RES), .PW(PW)) u_seq (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .running   (running),
    .ev_start  (ev_start),
    .ev_step   (ev_step),
    .ev_trial  (ev_trial),
    .ev_decide (ev_decide),
    .ev_last   (ev_last),
    .ev_end    (ev_end),
    .bit_pos   (bit_pos)
  );

  sar_search_reg #(.RES(RES), .PW(PW)) u_search (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .ev_start  (ev_start),
    .ev_trial  (ev_trial),
    .ev_decide (ev_decide),
    .ev_last   (ev_last),
    .bit_pos   (bit_pos),
    .comp_in   (comp_in),
    .dac_code  (dac_code),
    .result    (result),
    .done      (done)
  );

  sar_out_shift u_out (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ev_start  (ev_start),
    .ev_step   (ev_step),
    .ev_decide (ev_decide),
    .ev_end    (ev_end),
    .comp_in   (comp_in),
    .sdo_bit   (sdo_bit),
    .sdo_oe    (sdo_oe)
  );

  assign sdo    = sdo_oe ? sdo_bit : 1'bz;
  assign pwr_dn = cs_n | ~running;

endmodule

// File: rtl/sar_serial_ctrl_chk.sv
module sar_serial_ctrl_chk #(
  parameter int RES = 12
) (
  input logic           sclk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           sdo_oe,
  input logic           pwr_dn,
  input logic           done,
  input logic [RES-1:0] result,
  input logic [RES-1:0] dac_code,
  input logic           ev_start,
  input logic           ev_trial,
  input logic           ev_end,
  input logic           running
);

  a_r1_start_drives: assert property (@(posedge sclk) disable iff (!rst_n)
    ev_start |=> (sdo_oe || cs_n));

  a_r3_trial_top_bit: assert property (@(posedge sclk) disable iff (!rst_n)
    ev_trial |=> dac_code[RES-1]);

  a_r5_deselect_releases: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |=> !sdo_oe);

  a_r6_abort_no_done: assert property (@(posedge sclk) disable iff (!rst_n)
    (running && cs_n) |=> !done);

  a_r7_end_powers_down: assert property (@(posedge sclk) disable iff (!rst_n)
    ev_end |=> pwr_dn);

  a_r8_end_releases: assert property (@(posedge sclk) disable iff (!rst_n)
    ev_end |=> !sdo_oe);

  a_r9_done_single: assert property (@(posedge sclk) disable iff (!rst_n)
    done |=> !done);

  a_r9_result_with_done: assert property (@(posedge sclk) disable iff (!rst_n)
    !$stable(result) |-> done);

endmodule

bind sar_serial_ctrl sar_serial_ctrl_chk #(.RES(RES)) u_chk (
  .sclk     (sclk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sdo_oe   (sdo_oe),
  .pwr_dn   (pwr_dn),
  .done     (done),
  .result   (result),
  .dac_code (dac_code),
  .ev_start (ev_start),
  .ev_trial (ev_trial),
  .ev_end   (ev_end),
  .running  (running)
);

// File: tb/sar_serial_ctrl_bench.sv
`timescale 1ns/1ps
module sar_serial_ctrl_bench;
  localparam int CLK_PER = 10;

  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic [11:0] vin = '0;
  logic        comp_in;
  logic [11:0] dac_code;
  wire         sdo;
  logic        sdo_oe;
  logic        pwr_dn;
  logic [11:0] result;
  logic        done;

  int total = 0;
  int bad = 0;
  int done_seen = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;

  typedef struct { logic val; int idx; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PER/2) sclk = ~sclk;

  // ideal comparator: held input at or above trial code
  assign comp_in = (dac_code <= vin);

  sar_serial_ctrl u_sar_serial_ctrl (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .comp_in(comp_in),
    .dac_code(dac_code), .sdo(sdo), .sdo_oe(sdo_oe), .pwr_dn(pwr_dn),
    .result(result), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected serial bits while the line is driven
  always @(negedge sclk) begin
    if (rst_n && mon_en) begin
      if (done) done_seen++;
      if (sdo_oe) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 line driven outside frame", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(sdo === e.val, (e.idx < 4) ? "R2 leading zero" : "R2 result bit",
              int'(sdo), int'(e.val));
        end
      end
    end
  end

  // driver: one frame of nclk clocks with chip select low
  task automatic run_frame(input logic [11:0] code, input int nclk);
    logic [11:0] prev_res;
    int          prev_done;
    prev_res  = result;
    prev_done = done_seen;
    for (int k = 0; k < nclk && k < 16; k++) begin
      exp_t e;
      e.idx = k;
      e.val = (k < 4) ? 1'b0 : code[15 - k];
      exp_q.push_back(e);
    end
    @(negedge sclk); #1;
    vin  = code;
    cs_n = 1'b0;
    for (int k = 0; k < nclk; k++) begin
      @(negedge sclk);
      if (k == 0) chk(pwr_dn == 1'b0, "R7 active frame", int'(pwr_dn), 0);
      if (k == 0) chk(sdo_oe == 1'b1, "R1 driven after start", int'(sdo_oe), 1);
      if (k == 3) chk(dac_code == 12'h800, "R3 first trial", int'(dac_code), 'h800);
      if (k == 4) chk(dac_code == {code[11], 1'b1, 10'b0}, "R3 second trial",
                      int'(dac_code), int'({code[11], 1'b1, 10'b0}));
      if (k == 16) chk(pwr_dn == 1'b1, "R7 after frame end", int'(pwr_dn), 1);
    end
    #1;
    cs_n = 1'b1;
    #1;
    chk(sdo_oe == 1'b0, "R5 released on deselect", int'(sdo_oe), 0);
    chk(pwr_dn == 1'b1, "R7 idle on deselect", int'(pwr_dn), 1);
    repeat (2) @(negedge sclk);
    chk(exp_q.size() == 0, "R2 all bits shifted", exp_q.size(), 0);
    exp_q.delete();
    if (nclk >= 16) begin
      chk(result == code, "R4 full result", int'(result), int'(code));
      chk(done_seen == prev_done + 1, "R9 one done strobe", done_seen - prev_done, 1);
    end else begin
      chk(result == prev_res, "R6 result kept on short cycle", int'(result), int'(prev_res));
      chk(done_seen == prev_done, "R6 no done on short cycle", done_seen - prev_done, 0);
    end
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PER * 2 + 1);
    // R10 reset state
    chk(sdo_oe == 1'b0, "R10 reset enable", int'(sdo_oe), 0);
    chk(dac_code == 12'h000, "R10 reset code", int'(dac_code), 0);
    chk(result == 12'h000, "R10 reset result", int'(result), 0);
    chk(done == 1'b0, "R10 reset done", int'(done), 0);
    chk(pwr_dn == 1'b1, "R7 idle at reset", int'(pwr_dn), 1);
    @(negedge sclk); #1;
    rst_n  = 1'b1;
    mon_en = 1'b1;
    repeat (2) @(negedge sclk);

    // R4 boundary and pattern codes, full frames
    run_frame(12'hFFF, 16);
    run_frame(12'h000, 16);
    run_frame(12'h800, 16);
    run_frame(12'h7FF, 16);
    run_frame(12'h001, 16);
    run_frame(12'hAAA, 16);
    run_frame(12'h555, 16);
    for (int v = 37; v < 4096; v += 613) run_frame(12'(v), 16);

    // R8 chip select held low well past the frame
    run_frame(12'h3C5, 40);

    // R6 short cycles of different lengths
    run_frame(12'hB71, 9);
    run_frame(12'h6E4, 3);
    run_frame(12'hFFF, 15);
    run_frame(12'h2D9, 16);

    // R10 asynchronous reset in the middle of a frame
    mon_en = 1'b0;
    @(negedge sclk); #1;
    vin  = 12'hC3C;
    cs_n = 1'b0;
    repeat (8) @(negedge sclk);
    #1;
    rst_n = 1'b0;
    #1;
    chk(sdo_oe == 1'b0, "R10 reset mid-frame enable", int'(sdo_oe), 0);
    chk(dac_code == 12'h000, "R10 reset mid-frame code", int'(dac_code), 0);
    chk(result == 12'h000, "R10 reset mid-frame result", int'(result), 0);
    chk(pwr_dn == 1'b1, "R10 reset forces idle", int'(pwr_dn), 1);
    cs_n = 1'b1;
    @(negedge sclk); #1;
    rst_n = 1'b1;
    @(negedge sclk);
    mon_en = 1'b1;
    run_frame(12'h9A6, 16);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule